// File: doc/BRIEF.md
# Double-Buffered Channel Attenuation Register Bank

This block holds the digital attenuation settings for a six-channel audio output path (three left, three right). Each setting is an 8-bit code in half-decibel steps, from no attenuation (code 255) down to 127.5 dB of attenuation (code 0). Register writes arrive as a single-cycle write strobe carrying a 7-bit address and a 9-bit data word. The low eight bits are the code. The top bit asks for the new settings to take effect.

Every channel has two register stages. A write lands in that channel's pending stage. The active stage, which drives the outputs, is loaded only when some write has asked for an update. The load then happens at the next sample tick, and all six channels are loaded in the same clock cycle. A further address loads one code into all six pending stages at once. This lets software prepare several channels and then switch them together on a sample boundary.

Top module: `gsb_bank`

## Requirements
- R1: After a synchronous reset, all six pending codes and all six active codes are 8'hFF, and no update request is outstanding.
- R2: Addresses map to channels as follows: 0 to channel 0 (left 0), 1 to channel 1 (right 0), 4 to channel 2 (left 1), 5 to channel 3 (right 1), 6 to channel 4 (left 2) and 7 to channel 5 (right 2). Channel c appears on `act_codes_o[c*8 +: 8]`. A write with data bit 8 clear stores bits [7:0] in the addressed channel's pending register only, and leaves the outputs unchanged.
- R3: A write with data bit 8 set stores its code and raises an update request. At the first later clock edge where `smp_tick` is high, all six active codes take the six pending codes together.
- R4: The active outputs change only at a clock edge where `smp_tick` is high and an update request is outstanding. A tick with no request outstanding changes nothing.
- R5: A write to address 8 loads its code into all six pending registers. Data bit 8 then has the same meaning as in R2 and R3.
- R6: A write to any address other than 0, 1, 4, 5, 6, 7 or 8 changes no register and raises no update request, whatever its bit 8.
- R7: A write with bit 8 set in the same cycle as a tick does not transfer at that tick. The transfer happens at the following tick, and that write's code is included.
- R8: Several update writes before one tick cause a single transfer of the latest pending contents. The request is then cleared, so later ticks change nothing until a new update write arrives.
- R9: A transfer copies the pending contents held before that cycle. A bit-8-clear write made in the transfer cycle stays pending until a later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 7 | Register address |
| wr_data | input | 9 | Bits [7:0] attenuation code, bit 8 update request |
| smp_tick | input | 1 | One-cycle pulse marking a sample boundary |
| act_codes_o | output | 48 | Six active codes, channel c at bits [c*8 +: 8] |

## Verification
The assertions take the inputs to be synchronous to `clk`, and `wr_addr` and `wr_data` to be free of unknown values whenever `wr_en` is high. They also take `smp_tick` to be sampled only at clock edges; they do not require it to be a single pulse. The bench changes every input on the falling edge and returns `wr_en` and `smp_tick` low after each step, so every value is stable around the rising edge. The stimulus covers all 128 addresses, all 256 code values, and mixed patterns of write and tick, so both valid and unmapped addresses are applied while the properties are watched.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

  localparam int unsigned DEF_PAIRS   = 3;
  localparam int unsigned DEF_CODE_W  = 8;
  localparam int unsigned DEF_ADDR_W  = 7;
  localparam int unsigned DEF_MASTER  = 8;

  // Base address of a left/right channel pair: pair 0 at 0, others at 2+2p.
  function automatic int unsigned pair_base(input int unsigned p);
    return (p == 0) ? 0 : (2 + 2 * p);
  endfunction

  // Address of channel c (c = 2*pair + side, side 0 = left, 1 = right).
  function automatic int unsigned chan_addr(input int unsigned c);
    return pair_base(c / 2) + (c % 2);
  endfunction

endpackage

// File: rtl/gsb_decode.sv
module gsb_decode
  import gsb_pkg::*;
#(
  parameter int unsigned NCH         = 6,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned MASTER_ADDR = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W:0]   wr_data,
  output logic [NCH-1:0]    load_o,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);

  logic [NCH-1:0] hit;
  logic           is_master;

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    localparam int unsigned CA = chan_addr(c);
    assign hit[c] = (wr_addr == ADDR_W'(CA));
  end

  assign is_master = (wr_addr == ADDR_W'(MASTER_ADDR));

  always_comb begin
    load_o = '0;
    if (wr_en) begin
      load_o = is_master ? {NCH{1'b1}} : hit;
    end
  end

  assign code_o = wr_data[CODE_W-1:0];
  assign upd_o  = wr_en && (is_master || (|hit)) && wr_data[CODE_W];

endmodule

// File: rtl/gsb_pending.sv
module gsb_pending #(
  parameter int unsigned NCH    = 6,
  parameter int unsigned CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        load_i,
  input  logic [CODE_W-1:0]     code_i,
  output logic [NCH*CODE_W-1:0] pend_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic [CODE_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '1;
      end else if (load_i[c]) begin
        slot_q <= code_i;
      end
    end
    assign pend_o[c*CODE_W +: CODE_W] = slot_q;
  end

endmodule

// File: rtl/gsb_commit_ctl.sv
module gsb_commit_ctl (
  input  logic clk,
  input  logic rst,
  input  logic upd_i,
  input  logic tick_i,
  output logic xfer_o
);

  logic req_q;

  // A same-cycle update write defers the transfer to the next tick.
  assign xfer_o = tick_i && req_q && !upd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else if (upd_i) begin
      req_q <= 1'b1;
    end else if (xfer_o) begin
      req_q <= 1'b0;
    end
  end

endmodule

// File: rtl/gsb_active.sv
module gsb_active #(
  parameter int unsigned NCH    = 6,
  parameter int unsigned CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  xfer_i,
  input  logic [NCH*CODE_W-1:0] pend_i,
  output logic [NCH*CODE_W-1:0] act_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o <= '1;
    end else if (xfer_i) begin
      act_o <= pend_i;
    end
  end

endmodule

// File: rtl/gsb_bank.sv
module gsb_bank
  import gsb_pkg::*;
#(
  parameter int unsigned PAIRS       = DEF_PAIRS,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned MASTER_ADDR = DEF_MASTER,
  localparam int unsigned NCH        = 2 * PAIRS,
  localparam int unsigned BUS_W      = NCH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W:0]   wr_data,
  input  logic              smp_tick,
  output logic [BUS_W-1:0]  act_codes_o
);

  logic [NCH-1:0]    load;
  logic [CODE_W-1:0] code;
  logic              upd;
  logic              xfer;
  logic [BUS_W-1:0]  pend_q;

  gsb_decode #(
    .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .MASTER_ADDR(MASTER_ADDR)
  ) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .load_o (load),
    .code_o (code),
    .upd_o  (upd)
  );

  gsb_pending #(.NCH(NCH), .CODE_W(CODE_W)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .code_i(code),
    .pend_o(pend_q)
  );

  gsb_commit_ctl u_ctl (
    .clk   (clk),
    .rst   (rst),
    .upd_i (upd),
    .tick_i(smp_tick),
    .xfer_o(xfer)
  );

  gsb_active #(.NCH(NCH), .CODE_W(CODE_W)) u_act (
    .clk   (clk),
    .rst   (rst),
    .xfer_i(xfer),
    .pend_i(pend_q),
    .act_o (act_codes_o)
  );

endmodule

// File: rtl/gsb_bank_chk.sv
module gsb_bank_chk
  import gsb_pkg::*;
#(
  parameter int unsigned NCH         = 6,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned MASTER_ADDR = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [CODE_W:0]       wr_data,
  input logic                  smp_tick,
  input logic [NCH*CODE_W-1:0] pend,
  input logic                  xfer,
  input logic [NCH*CODE_W-1:0] act
);

  logic addr_ok;
  always_comb begin
    addr_ok = (wr_addr == ADDR_W'(MASTER_ADDR));
    for (int c = 0; c < NCH; c++) begin
      if (wr_addr == ADDR_W'(chan_addr(c))) addr_ok = 1'b1;
    end
  end

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    !smp_tick |=> $stable(act));

  assert_xfer_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
    xfer |-> smp_tick);

  assert_copy_pending_R3: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (act == $past(pend)));

  assert_master_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(MASTER_ADDR)) |=>
      (pend == {NCH{$past(wr_data[CODE_W-1:0])}}));

  assert_bad_addr_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_ok) |=> $stable(pend));

  assert_defer_same_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (smp_tick && wr_en && addr_ok && wr_data[CODE_W]) |-> !xfer);

endmodule

bind gsb_bank gsb_bank_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .MASTER_ADDR(MASTER_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .smp_tick(smp_tick),
  .pend    (pend_q),
  .xfer    (xfer),
  .act     (act_codes_o)
);

// File: tb/gsb_bank_tb.sv
module gsb_bank_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [6:0]  wr_addr;
  logic [8:0]  wr_data;
  logic        smp_tick;
  logic [47:0] act_codes_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] m_pend [6];
  logic [7:0] m_act  [6];
  bit         m_req;

  always #10 clk = ~clk;

  gsb_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .smp_tick(smp_tick), .act_codes_o(act_codes_o)
  );

  function automatic int chan_of(input int a);
    case (a)
      0: return 0;
      1: return 1;
      4: return 2;
      5: return 3;
      6: return 4;
      7: return 5;
      8: return 6;
      default: return -1;
    endcase
  endfunction

  task automatic check_act(input string tag);
    logic [47:0] exp;
    for (int i = 0; i < 6; i++) exp[i*8 +: 8] = m_act[i];
    n_checks++;
    if (act_codes_o !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act_codes_o, exp);
    end
  endtask

  task automatic step(input bit we, input int a, input bit upd,
                      input logic [7:0] code, input bit tk, input string tag);
    int  ch;
    bit  wupd;
    wr_en    = we;
    wr_addr  = a[6:0];
    wr_data  = {upd, code};
    smp_tick = tk;
    @(posedge clk);
    ch   = chan_of(a);
    wupd = we && (ch >= 0) && upd;
    if (tk && m_req && !wupd) begin
      for (int i = 0; i < 6; i++) m_act[i] = m_pend[i];
      m_req = 0;
    end
    if (we && ch >= 0) begin
      if (ch == 6) for (int i = 0; i < 6; i++) m_pend[i] = code;
      else m_pend[ch] = code;
      if (upd) m_req = 1;
    end
    @(negedge clk);
    wr_en    = 0;
    smp_tick = 0;
    check_act(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int addrs [7] = '{0, 1, 4, 5, 6, 7, 8};
    rst = 1; wr_en = 0; wr_addr = '0; wr_data = '0; smp_tick = 0;
    for (int i = 0; i < 6; i++) begin m_pend[i] = 8'hFF; m_act[i] = 8'hFF; end
    m_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check_act("R1");

    // R2/R6: every address with bit 8 clear leaves outputs alone
    for (int a = 0; a < 128; a++) step(1, a, 0, 8'(a * 3 + 1), 0, "R2,R6");
    step(0, 0, 0, 8'h00, 1, "R6");
    // R4: update request waits for the tick
    step(1, 0, 1, 8'h10, 0, "R4");
    step(0, 0, 0, 8'h00, 0, "R4");
    step(0, 0, 0, 8'h00, 1, "R3");
    step(0, 0, 0, 8'h00, 1, "R8");
    // R5: master fill, then per-channel override
    step(1, 8, 0, 8'h33, 0, "R5");
    step(1, 5, 0, 8'h44, 0, "R5");
    step(1, 9, 1, 8'h55, 0, "R6");
    step(0, 0, 0, 8'h00, 1, "R6");
    step(1, 1, 1, 8'h22, 0, "R5");
    step(0, 0, 0, 8'h00, 1, "R5");
    step(1, 8, 1, 8'h66, 0, "R5");
    step(0, 0, 0, 8'h00, 1, "R5");
    // R7: update write coinciding with a tick
    step(1, 4, 1, 8'h77, 1, "R7");
    step(0, 0, 0, 8'h00, 1, "R7");
    step(0, 0, 0, 8'h00, 1, "R7");
    // R8: several updates before one tick
    step(1, 0, 1, 8'h01, 0, "R8");
    step(1, 0, 1, 8'h02, 0, "R8");
    step(1, 8, 1, 8'h03, 0, "R8");
    step(1, 7, 0, 8'h09, 0, "R8");
    step(0, 0, 0, 8'h00, 1, "R8");
    step(0, 0, 0, 8'h00, 1, "R8");
    // R9: plain write during a transfer stays pending
    step(1, 6, 1, 8'hA0, 0, "R9");
    step(1, 6, 0, 8'hB0, 1, "R9");
    step(0, 0, 0, 8'h00, 1, "R9");
    step(1, 1, 1, 8'hC0, 0, "R9");
    step(0, 0, 0, 8'h00, 1, "R9");
    // R3: every code value through every valid address
    for (int k = 0; k < 256; k++) begin
      step(1, addrs[k % 7], 1, 8'(k), 0, "R3");
      step(0, 0, 0, 8'h00, 1, "R3");
    end
    // R4: mixed pattern of writes, flags and ticks
    for (int i = 0; i < 400; i++)
      step(i % 3 != 0, (i * 37) % 12, i % 5 == 0, 8'(i * 29), i % 4 == 0, "R4");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule